// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block turns message-signalled interrupts into one level-sensitive interrupt line for the host CPU. An endpoint signals an interrupt by writing a vector number to a doorbell address. Software programs that address, along with three per-vector registers: enable, mask and status. A doorbell write sets one status bit, chosen by the data value, but only when the enable bit for that vector is set. The interrupt line is driven high when status holds a bit whose mask bit is clear. Software clears status by writing back the bits it read.

There are two ports. The register port is a plain 32-bit port. Writes are strobed by `reg_wr`, and the read data follows `reg_addr` combinationally. The doorbell port is a valid/ready write channel carrying a 64-bit address, 32 bits of data and four byte strobes, with byte lane 0 on bits 7:0. The block lowers `db_ready` in every cycle where `reg_wr` is high. A doorbell beat is taken only in a cycle where `db_valid` and `db_ready` are both high. The sender must hold the beat stable until it is taken. In every other cycle `db_ready` is high.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: After reset, all of these read zero: the 64-bit doorbell address, enable, mask and status. `irq` is low.
- R2: The register offsets are: 0x820 for doorbell address bits 31:0, 0x824 for bits 63:32, 0x828 for enable, 0x82C for mask and 0x830 for status. Writing either address half replaces only that half. Both halves read back.
- R3: Enable and mask take the written value and read it back. Any other offset reads zero.
- R4: Consider an accepted doorbell beat that matches the window and carries data value v, below the vector count. If enable bit v is set, status bit v is set on the next clock edge. No other status bit changes.
- R5: A doorbell beat for a disabled vector is dropped. So is a beat whose data value is 32 or greater. Neither changes status.
- R6: A beat matches the window only when all three hold: enable is nonzero, the address equals the programmed 64-bit address, and all four strobes are set. A beat that does not match changes neither status nor `irq`.
- R7: After a matching beat, `irq` goes high on the next edge if any status bit is set whose mask bit is clear.
- R8: A status register write flips each status bit that is 1 in the written value.
- R9: `irq` falls only on a status write that leaves status all zero. Writing the mask does not lower it, and neither does a partial clear.
- R10: `db_ready` is low in any cycle with `reg_wr` high. A beat held across that cycle is taken on the next cycle where `db_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| db_valid | input | 1 | Doorbell beat valid |
| db_ready | output | 1 | Doorbell beat ready |
| db_addr | input | 64 | Doorbell target address |
| db_data | input | 32 | Doorbell data (vector number) |
| db_strb | input | 4 | Doorbell byte strobes |
| irq | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with the default vector count of 32. This makes vector 31 the highest legal vector and data value 32 the first one that must be dropped. It also means every bit of the 32-bit enable, mask and status words is live.

The random phase mixes four kinds of operation: beats at the programmed address, beats at nearby wrong addresses, beats with partial strobes, and register writes that reprogram the window while it is open. This reaches cases that directed tests rarely cover, such as a disabled-vector beat raising `irq` from an older pending bit.

// File: rtl/msi_db_pkg.sv
`timescale 1ns/1ps
package msi_db_pkg;
  localparam int OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_ADDR_LO = 12'h820;
  localparam logic [OFS_W-1:0] OFS_ADDR_HI = 12'h824;
  localparam logic [OFS_W-1:0] OFS_ENABLE  = 12'h828;
  localparam logic [OFS_W-1:0] OFS_MASK    = 12'h82C;
  localparam logic [OFS_W-1:0] OFS_STATUS  = 12'h830;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_ADDR_LO, SEL_ADDR_HI, SEL_ENABLE, SEL_MASK, SEL_STATUS
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
    case (ofs)
      OFS_ADDR_LO: decode_ofs = SEL_ADDR_LO;
      OFS_ADDR_HI: decode_ofs = SEL_ADDR_HI;
      OFS_ENABLE:  decode_ofs = SEL_ENABLE;
      OFS_MASK:    decode_ofs = SEL_MASK;
      OFS_STATUS:  decode_ofs = SEL_STATUS;
      default:     decode_ofs = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/msi_db_regfile.sv
`timescale 1ns/1ps
module msi_db_regfile
  import msi_db_pkg::*;
#(
  parameter int NVEC = 32,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [OFS_W-1:0] addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NVEC-1:0] status,
  output logic [DW-1:0]   rdata,
  output logic [2*DW-1:0] bell_addr,
  output logic [NVEC-1:0] enable,
  output logic [NVEC-1:0] mask,
  output logic            status_wr
);
  reg_sel_e sel;
  logic [DW-1:0] lo_q, hi_q;

  assign sel       = decode_ofs(addr);
  assign status_wr = wr && (sel == SEL_STATUS);
  assign bell_addr = {hi_q, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      enable <= '0;
      mask   <= '0;
    end else if (wr) begin
      case (sel)
        SEL_ADDR_LO: lo_q   <= wdata;
        SEL_ADDR_HI: hi_q   <= wdata;
        SEL_ENABLE:  enable <= wdata[NVEC-1:0];
        SEL_MASK:    mask   <= wdata[NVEC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_ADDR_LO: rdata = lo_q;
      SEL_ADDR_HI: rdata = hi_q;
      SEL_ENABLE:  rdata = DW'(enable);
      SEL_MASK:    rdata = DW'(mask);
      SEL_STATUS:  rdata = DW'(status);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/msi_db_window.sv
`timescale 1ns/1ps
module msi_db_window #(
  parameter int NVEC = 32,
  parameter int AW   = 64,
  parameter int SW   = 4
) (
  input  logic            fire,
  input  logic [AW-1:0]   db_addr,
  input  logic [SW-1:0]   db_strb,
  input  logic [AW-1:0]   bell_addr,
  input  logic [NVEC-1:0] enable,
  output logic            hit
);
  logic open, addr_eq, full_word;
  assign open      = |enable;
  assign addr_eq   = (db_addr == bell_addr);
  assign full_word = &db_strb;
  assign hit       = fire && open && addr_eq && full_word;
endmodule

// File: rtl/msi_db_vector.sv
`timescale 1ns/1ps
module msi_db_vector #(
  parameter int NVEC = 32,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic [DW-1:0]   vec,
  input  logic [NVEC-1:0] enable,
  input  logic [NVEC-1:0] mask,
  input  logic            status_wr,
  input  logic [DW-1:0]   wdata,
  output logic [NVEC-1:0] status,
  output logic            irq
);
  logic [NVEC-1:0] set_bits, status_nx;

  for (genvar i = 0; i < NVEC; i++) begin : g_set
    assign set_bits[i] = hit && (vec == DW'(i)) && enable[i];
  end

  always_comb begin
    if (status_wr) status_nx = status ^ wdata[NVEC-1:0];
    else           status_nx = status | set_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_nx;
      if (hit && |(status_nx & ~mask))      irq <= 1'b1;
      else if (status_wr && status_nx == '0) irq <= 1'b0;
    end
  end
endmodule

// File: rtl/msi_doorbell_ctrl.sv
`timescale 1ns/1ps
module msi_doorbell_ctrl
  import msi_db_pkg::*;
#(
  parameter int NVEC = 32,
  parameter int DW   = 32,
  parameter int AW   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             db_valid,
  output logic             db_ready,
  input  logic [AW-1:0]    db_addr,
  input  logic [DW-1:0]    db_data,
  input  logic [DW/8-1:0]  db_strb,
  output logic             irq
);
  localparam int SW = DW / 8;

  logic [AW-1:0]   bell_addr;
  logic [NVEC-1:0] enable, mask, status_q;
  logic            status_wr, fire, hit;

  assign db_ready = !reg_wr;
  assign fire     = db_valid && db_ready;

  msi_db_regfile #(.NVEC(NVEC), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .status(status_q), .rdata(reg_rdata),
    .bell_addr(bell_addr), .enable(enable), .mask(mask),
    .status_wr(status_wr)
  );

  msi_db_window #(.NVEC(NVEC), .AW(AW), .SW(SW)) u_win (
    .fire(fire), .db_addr(db_addr), .db_strb(db_strb),
    .bell_addr(bell_addr), .enable(enable), .hit(hit)
  );

  msi_db_vector #(.NVEC(NVEC), .DW(DW)) u_vec (
    .clk(clk), .rst_n(rst_n), .hit(hit), .vec(db_data),
    .enable(enable), .mask(mask), .status_wr(status_wr),
    .wdata(reg_wdata), .status(status_q), .irq(irq)
  );
endmodule

// File: rtl/msi_doorbell_chk.sv
`timescale 1ns/1ps
module msi_doorbell_chk #(
  parameter int NVEC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [11:0]     reg_addr,
  input logic            db_valid,
  input logic            db_ready,
  input logic            irq,
  input logic [NVEC-1:0] status
);
  AST_READY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !db_ready); // R10
  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(db_valid && db_ready)); // R7
  AST_IRQ_FALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (status == '0) && $past(reg_wr && reg_addr == 12'h830)); // R9
  AST_STATUS_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status)) != '0) |->
      $past(db_valid && db_ready) || $past(reg_wr && reg_addr == 12'h830)); // R4
  AST_ONE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(db_valid && db_ready) |-> $countones(status & ~$past(status)) <= 1); // R4
endmodule

bind msi_doorbell_ctrl msi_doorbell_chk #(.NVEC(NVEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .db_valid(db_valid), .db_ready(db_ready), .irq(irq), .status(status_q)
);

// File: tb/msi_doorbell_ctrl_test.sv
`timescale 1ns/1ps
module msi_doorbell_ctrl_test;
  localparam logic [11:0] A_LO = 12'h820, A_HI = 12'h824, A_EN = 12'h828,
                          A_MK = 12'h82C, A_ST = 12'h830;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic db_valid = 0, db_ready;
  logic [63:0] db_addr = 0;
  logic [31:0] db_data = 0;
  logic [3:0]  db_strb = 0;
  logic irq;

  int checks = 0, fails = 0;
  logic [63:0] m_addr = 0;
  logic [31:0] m_en = 0, m_mask = 0, m_stat = 0;
  logic m_irq = 0;

  always #2.5 clk = ~clk;

  msi_doorbell_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_valid(db_valid),
    .db_ready(db_ready), .db_addr(db_addr), .db_data(db_data),
    .db_strb(db_strb), .irq(irq)
  );

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      A_LO: return m_addr[31:0];
      A_HI: return m_addr[63:32];
      A_EN: return m_en;
      A_MK: return m_mask;
      A_ST: return m_stat;
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit win_hit(input logic [63:0] a, input logic [3:0] s);
    return (m_en != 0) && (a == m_addr) && (s == 4'hF);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_check(input string req, input logic [11:0] a);
    reg_addr = a; #0.1;
    check(req, reg_rdata, exp_read(a));
  endtask

  task automatic check_all(input string req);
    rd_check(req, A_LO); rd_check(req, A_HI); rd_check(req, A_EN);
    rd_check(req, A_MK); rd_check(req, A_ST);
    check({req, " irq"}, irq, m_irq);
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    case (a)
      A_LO: m_addr[31:0]  = d;
      A_HI: m_addr[63:32] = d;
      A_EN: m_en = d;
      A_MK: m_mask = d;
      A_ST: begin m_stat ^= d; if (m_stat == 0) m_irq = 0; end
      default: ;
    endcase
  endtask

  task automatic doorbell(input logic [63:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    db_valid = 1; db_addr = a; db_data = d; db_strb = s;
    @(negedge clk);
    db_valid = 0;
    if (win_hit(a, s)) begin
      if (d < 32 && m_en[d[4:0]]) m_stat[d[4:0]] = 1'b1;
      if ((m_stat & ~m_mask) != 0) m_irq = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] bell;
    bell = 64'h0000_00F0_FEE0_0040;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check_all("R1 reset");
    rd_check("R3 unmapped", 12'h834);

    reg_write(A_LO, bell[31:0]);
    check_all("R2 low half");
    reg_write(A_HI, bell[63:32]);
    check_all("R2 high half");
    reg_write(A_LO, 32'h1234_5678);
    check_all("R2 low keeps high");
    reg_write(A_LO, bell[31:0]);

    doorbell(bell, 32'd3, 4'hF);
    check_all("R6 window closed");

    reg_write(A_EN, 32'h8000_0021);
    check_all("R3 enable readback");
    reg_write(A_MK, 32'h0000_0001);
    check_all("R3 mask readback");

    doorbell(bell, 32'd6, 4'hF);
    check_all("R5 disabled vector");
    doorbell(bell, 32'd32, 4'hF);
    check_all("R5 vector 32");
    doorbell(bell ^ 64'h1_0000_0000, 32'd5, 4'hF);
    check_all("R6 wrong high addr");
    doorbell(bell, 32'd5, 4'h7);
    check_all("R6 partial strobe");

    doorbell(bell, 32'd0, 4'hF);
    check_all("R4 masked vector 0");
    check("R7 masked no irq", irq, 1'b0);
    doorbell(bell, 32'd31, 4'hF);
    check_all("R4 vector 31");
    check("R7 irq up", irq, 1'b1);
    doorbell(bell, 32'd5, 4'hF);
    check_all("R4 vector 5");

    reg_write(A_MK, 32'hFFFF_FFFF);
    check("R9 mask no drop", irq, 1'b1);
    reg_write(A_ST, 32'h8000_0000);
    check_all("R8 partial clear");
    check("R9 partial keeps irq", irq, 1'b1);
    reg_write(A_ST, 32'h0000_0100);
    check_all("R8 xor sets bit");
    reg_write(A_ST, 32'h0000_0121);
    check_all("R9 full clear");
    check("R9 irq low", irq, 1'b0);
    reg_write(A_MK, 32'h0);

    @(negedge clk);
    reg_wr = 1; reg_addr = A_MK; reg_wdata = 32'h0;
    db_valid = 1; db_addr = bell; db_data = 32'd5; db_strb = 4'hF;
    #0.1;
    check("R10 ready low", db_ready, 1'b0);
    @(negedge clk);
    reg_wr = 0;
    #0.1;
    check("R10 held not taken", {reg_rdata, 31'b0, irq}, {32'h0, 32'h0});
    check("R10 ready high", db_ready, 1'b1);
    @(negedge clk);
    db_valid = 0;
    m_stat[5] = 1; m_irq = 1;
    check_all("R10 taken later");

    for (int i = 0; i < 400; i++) begin
      int unsigned k;
      k = $urandom_range(0, 9);
      if (k < 5) begin
        logic [63:0] a;
        logic [3:0] s;
        a = ($urandom_range(0, 3) == 0) ? (m_addr ^ (64'h1 << $urandom_range(0, 63))) : m_addr;
        s = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
        doorbell(a, 32'($urandom_range(0, 40)), s);
      end else if (k < 7) begin
        reg_write(A_ST, m_stat & $urandom());
      end else if (k == 7) begin
        reg_write(A_MK, $urandom() & $urandom());
      end else if (k == 8) begin
        reg_write(A_EN, ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom());
      end else begin
        reg_write($urandom_range(0, 1) ? A_LO : A_HI, $urandom());
      end
      check_all("R4 R5 R6 R7 R8 R9 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule